// File: doc/BRIEF.md
# Overwrite-on-full circular byte FIFO

This block is a small circular byte queue for the receive or transmit path of a serial port register model. A producer pushes bytes with a write strobe and a consumer pulls them with a read strobe. Both strobes are independent and may be raised in the same cycle.

When the queue is already full, a write is never refused. The new byte takes the place of the oldest one, so the queue always holds the most recent bytes. A read from an empty queue returns a byte of all ones and leaves the queue untouched.

A synchronous flush input empties the queue in one cycle. The outputs are the registered read byte, the occupancy count, and empty and full flags.

Top module: `byteq_fifo`

## Requirements
- R1: After reset the count is 0, `empty` is 1, `full` is 0 and `rdData` is all ones.
- R2: A write while the count is below DEPTH stores the byte and raises the count by one.
- R3: A read while the count is nonzero presents the oldest stored byte on `rdData` in the cycle after the strobe and lowers the count by one.
- R4: A write alone while the count equals DEPTH keeps the count at DEPTH and discards the oldest byte, so later reads return the newest DEPTH bytes in order.
- R5: A read while the count is 0 and no write is present puts all ones (0xFF at WIDTH 8) on `rdData` in the next cycle and leaves the count at 0.
- R6: A read together with a write while the count is nonzero leaves the count unchanged, returns the oldest byte and appends the new one. This includes the full case, where nothing is dropped.
- R7: A read together with a write while the count is 0 performs only the write. `rdData` becomes all ones and the count becomes 1.
- R8: A flush sets the count to 0 in the next cycle and takes priority over a read or write in the same cycle. Those strobes have no effect and `rdData` keeps its value.
- R9: `empty` is 1 exactly when the count is 0, `full` is 1 exactly when the count equals DEPTH, and the count never exceeds DEPTH.
- R10: Byte order is preserved across any number of pointer wraps. DEPTH must be a power of two, at least 2.
- R11: `rdData` holds its value in any cycle without an accepted or empty read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of the queue |
| wrEn | input | 1 | Write strobe |
| wrData | input | WIDTH | Byte to store |
| rdEn | input | 1 | Read strobe |
| rdData | output | WIDTH | Registered read byte |
| count | output | $clog2(DEPTH+1) | Occupancy |
| empty | output | 1 | Count is zero |
| full | output | 1 | Count equals DEPTH |

## Verification
The bench builds the block with DEPTH 4 and WIDTH 8. The small depth makes the full state reachable within a handful of writes, so overwrite, full read-with-write and flush can be reached in a short vector table. A long interleaved run then wraps the two-bit pointers many times against a queue model in the bench, which exposes any pointer or count slip at the rollover.

// File: rtl/byteq_pkg.sv
package byteq_pkg;
  typedef struct packed {
    logic store;      // write the input byte at the write address
    logic pop;        // load the byte at the read address into rdData
    logic emptyRead;  // read of an empty queue: load all ones
  } byteq_stb_t;
endpackage

// File: rtl/byteq_ctrl.sv
module byteq_ctrl #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                flush,
  input  logic                wrEn,
  input  logic                rdEn,
  output byteq_pkg::byteq_stb_t stb,
  output logic [PTR_W-1:0]    wrAddr,
  output logic [PTR_W-1:0]    rdAddr,
  output logic [CNT_W-1:0]    count,
  output logic                empty,
  output logic                full
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  generate
    if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("byteq_ctrl: DEPTH must be a power of two, at least 2");
    end
  endgenerate

  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] cnt;
  logic isEmpty, isFull, doWrite, doRead, emptyRd, dropOldest;

  assign isEmpty    = (cnt == '0);
  assign isFull     = (cnt == CNT_MAX);
  assign doWrite    = wrEn && !flush;
  assign doRead     = rdEn && !flush && !isEmpty;
  assign emptyRd    = rdEn && !flush && isEmpty;
  assign dropOldest = doWrite && isFull && !doRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (doWrite) wrPtr <= wrPtr + 1'b1;
      if (doRead || dropOldest) rdPtr <= rdPtr + 1'b1;
      if (doWrite && !doRead && !isFull) cnt <= cnt + 1'b1;
      else if (doRead && !doWrite) cnt <= cnt - 1'b1;
    end
  end

  assign stb.store     = doWrite;
  assign stb.pop       = doRead;
  assign stb.emptyRead = emptyRd;
  assign wrAddr = wrPtr;
  assign rdAddr = rdPtr;
  assign count  = cnt;
  assign empty  = isEmpty;
  assign full   = isFull;

  // R9
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_MAX);
  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (cnt == '0));
  // R4
  full_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdEn && !flush && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && !flush && cnt == '0) |=> (cnt == '0));
  // R6
  both_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && wrEn && !flush && cnt != '0) |=> $stable(cnt));
  // R7
  empty_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && wrEn && !flush && cnt == '0) |=> (cnt == CNT_W'(1)));
endmodule

// File: rtl/byteq_data.sv
module byteq_data #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  byteq_pkg::byteq_stb_t stb,
  input  logic [PTR_W-1:0]      wrAddr,
  input  logic [PTR_W-1:0]      rdAddr,
  input  logic [WIDTH-1:0]      wrData,
  output logic [WIDTH-1:0]      rdData
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdReg;

  always_ff @(posedge clk) begin
    if (stb.store) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rdReg <= '1;
    else if (stb.pop)       rdReg <= mem[rdAddr];
    else if (stb.emptyRead) rdReg <= '1;
  end

  assign rdData = rdReg;

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.pop && !stb.emptyRead) |=> $stable(rdData));
  // R5
  empty_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.emptyRead |=> (rdData == '1));
endmodule

// File: rtl/byteq_fifo.sv
module byteq_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  byteq_pkg::byteq_stb_t stb;
  logic [PTR_W-1:0] wrAddr, rdAddr;

  byteq_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .flush(flush), .wrEn(wrEn), .rdEn(rdEn),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .count(count), .empty(empty), .full(full)
  );

  byteq_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/tb_byteq_fifo.sv
module tb_byteq_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int WIDTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [WIDTH-1:0] wrData = '0;
  logic [WIDTH-1:0] rdData;
  logic [CNT_W-1:0] count;
  logic empty, full;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byteq_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk(clk), .rstN(rstN), .flush(flush), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .count(count), .empty(empty), .full(full)
  );

  // {flush, wr, rd, data, expected rdData, expected count}
  localparam int NV = 18;
  localparam logic [21:0] VEC [NV] = '{
    {3'b001, 8'h00, 8'hFF, 3'd0},  // R5 empty read
    {3'b010, 8'h11, 8'hFF, 3'd1},  // R2
    {3'b010, 8'h22, 8'hFF, 3'd2},
    {3'b010, 8'h33, 8'hFF, 3'd3},
    {3'b010, 8'h44, 8'hFF, 3'd4},  // now full
    {3'b010, 8'h55, 8'hFF, 3'd4},  // R4 drops 11
    {3'b001, 8'h00, 8'h22, 3'd3},  // R3/R4
    {3'b011, 8'h66, 8'h33, 3'd3},  // R6
    {3'b001, 8'h00, 8'h44, 3'd2},
    {3'b001, 8'h00, 8'h55, 3'd1},
    {3'b001, 8'h00, 8'h66, 3'd0},
    {3'b001, 8'h00, 8'hFF, 3'd0},  // R5
    {3'b011, 8'h77, 8'hFF, 3'd1},  // R7
    {3'b000, 8'h00, 8'hFF, 3'd1},  // R11 hold
    {3'b001, 8'h00, 8'h77, 3'd0},
    {3'b010, 8'h88, 8'h77, 3'd1},  // R11 hold across write
    {3'b111, 8'h99, 8'h77, 3'd0},  // R8 flush wins
    {3'b001, 8'h00, 8'hFF, 3'd0}   // R8 nothing left
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(bit f, bit w, bit r, logic [7:0] d);
    flush = f; wrEn = w; rdEn = r; wrData = d;
    @(negedge clk);
    flush = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic checkFlags(string req);
    check(req, {31'd0, empty}, {31'd0, count == 0});
    check(req, {31'd0, full},  {31'd0, count == DEPTH});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] model [$];
    logic [7:0] expRd;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1", {29'd0, count}, 32'd0);
    check("R1", {31'd0, empty}, 32'd1);
    check("R1", {31'd0, full}, 32'd0);
    check("R1", {24'd0, rdData}, 32'hFF);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][21], VEC[i][20], VEC[i][19], VEC[i][18:11]);
      check($sformatf("R3/R4/R5 vec%0d", i), {24'd0, rdData}, {24'd0, VEC[i][10:3]});
      check($sformatf("R2/R8 vec%0d", i), {29'd0, count}, {29'd0, VEC[i][2:0]});
      checkFlags("R9");
    end

    // R6 full with read and write: no drop
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 8'hA0 + 8'(i));
    check("R9 full", {31'd0, full}, 32'd1);
    step(0, 1, 1, 8'hB0);
    check("R6", {24'd0, rdData}, 32'hA0);
    check("R6", {29'd0, count}, DEPTH);
    for (int i = 1; i < DEPTH; i++) begin
      step(0, 0, 1, 8'h00);
      check("R6", {24'd0, rdData}, 32'hA0 + i);
    end
    step(0, 0, 1, 8'h00);
    check("R6", {24'd0, rdData}, 32'hB0);
    check("R9", {31'd0, empty}, 32'd1);

    // R4 overwrite twice past full
    for (int i = 0; i < DEPTH + 2; i++) step(0, 1, 0, 8'hC0 + 8'(i));
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 0, 1, 8'h00);
      check("R4", {24'd0, rdData}, 32'hC2 + i);
    end

    // R10 wrap run against queue model
    expRd = rdData;
    for (int i = 0; i < 200; i++) begin
      bit w, r;
      logic [7:0] d;
      w = ((i * 7) % 5) < 3;
      r = ((i * 11) % 7) < 4;
      d = 8'(i * 37 + 5);
      if (r) begin
        if (model.size() > 0) expRd = model.pop_front();
        else expRd = 8'hFF;
      end
      if (w) begin
        if (model.size() == DEPTH) void'(model.pop_front());
        model.push_back(d);
      end
      step(0, w, r, d);
      check("R10", {24'd0, rdData}, {24'd0, expRd});
      check("R10", {29'd0, count}, model.size());
      checkFlags("R9");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule